// File: doc/BRIEF.md
# Clock gear and warm-up controller

This block sits in the clock-management corner of a small microcontroller. Software programs three byte-wide control registers through a single-cycle write port and a combinational read port. The registers drive the run enables of a fast and a slow oscillator, the system clock choice, the divide ratio applied to the fast clock, the prescaler source, and the clock routed to an output pin. Clocks are not generated here: every result is a level or an enable that downstream clock cells consume.

An oscillator warm-up counter is started by writing a one to a dedicated bit of register 0. The same bit reads back as one while the count runs and as zero once it has expired. The count length is chosen from three powers of two. A halt request moves the block into the halt mode held in register 2. In STOP both oscillator enables are forced low. A wake event leaves IDLE at once. Leaving STOP loads a separately programmed pair of oscillator enables, waits out a warm-up period and only then applies the programmed post-stop clock choice.

Top module: `clkgear_ctrl`

## Requirements
- R1: After reset, register 0 (address 0) reads 8'hE0, register 1 (address 1) reads 8'h04 and register 2 (address 2) reads 8'h2C. Both oscillators are enabled, the fast clock is selected at gear code 100, and the block is running (halt_mode = 00).
- R2: Register 0 layout: bit 7 is the fast oscillator enable, bit 6 the slow oscillator enable, bit 5 and bit 4 the fast and slow enables applied on leaving STOP, bit 3 the clock applied on leaving STOP (0 fast, 1 slow), bit 2 the warm-up control, bits 1:0 the prescaler select (00 gear clock, 10 fast/16, 01 and 11 reserved, stored as written). Bits 7, 6 and 1:0 drive hosc_en, losc_en and presc_sel on the cycle after the write.
- R3: Writing register 0 with bit 2 = 1 starts the warm-up count. Register 0 bit 2 then reads 1 for exactly the programmed number of cycles and 0 afterwards. Writing bit 2 = 0 neither starts nor stops a count.
- R4: Register 2 bits 5:4 select the warm-up length: 01 gives 256 cycles, 10 gives 16384, 11 gives 65536, and the reserved code 00 gives 16384. The field reads back as written.
- R5: Register 1 bits 2:0 are the gear code, output on gear_sel (000 fc, 001 fc/2, 010 fc/4, 011 fc/8, 100 fc/16). A write carrying a code of 101 to 111 leaves the gear unchanged.
- R6: Register 1 bit 3 selects the system clock (0 fast, 1 slow) on sysclk_sel. Register 1 bits 7:4 read as zero.
- R7: Register 2 bit 6 drives clkout_sel (0 slow clock, 1 system clock). Register 2 bit 7 reads as zero. Address 3 reads as zero, and writes to it change nothing.
- R8: Register 2 bits 3:2 hold the halt mode: 01 STOP, 10 IDLE1, 11 IDLE2. A halt_req while running enters that mode on the next cycle, and halt_mode reports its code. A halt_req with code 00 is ignored.
- R9: While in STOP, hosc_en and losc_en are both 0 whatever register 0 holds. A wake in IDLE1 or IDLE2 returns halt_mode to 00 on the next cycle.
- R10: A wake in STOP copies register 0 bits 5:4 into bits 7:6 and starts a warm-up count. halt_mode stays 01 until the count has expired. sysclk_sel takes register 0 bit 3 exactly N+1 cycles after the wake cycle, where N is the warm-up length, and halt_mode returns to 00 in that same cycle.
- R11: Register 2 bit 1 picks the mode in which pins are controlled (0 STOP, including the warm-up after wake; 1 IDLE1). Bit 0 = 0 switches pins off in that mode (pin_off = 1), and bit 0 = 1 keeps their state. pin_off is 0 in all other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the warm-up count advances on each edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| halt_req | input | 1 | Request to enter the programmed halt mode |
| wake | input | 1 | Wake event that ends a halt |
| hosc_en | output | 1 | Fast oscillator enable |
| losc_en | output | 1 | Slow oscillator enable |
| sysclk_sel | output | 1 | System clock select, 0 fast, 1 slow |
| gear_sel | output | 3 | Fast clock divide code |
| presc_sel | output | 2 | Prescaler source code |
| clkout_sel | output | 1 | Output pin clock select |
| halt_mode | output | 2 | 00 running, 01 STOP or post-stop warm-up, 10 IDLE1, 11 IDLE2 |
| pin_off | output | 1 | Pins switched off during the current halt |

## Verification
Every registered result (oscillator enables, gear, clock selects, halt mode, pin control) changes one cycle after the write, halt request or wake that causes it. The warm-up status bit reads one from the cycle after the start for exactly N cycles, and the post-stop clock switch lands N+1 cycles after the wake. The bench drives its inputs 2 ns after a rising edge and compares every output, and the read data at the current address, with a behavioural model at each falling edge, so every result is checked in the cycle it is due. Named checks then count warm-up and wake-to-switch cycles directly against 256, 16384 and 65536.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;

  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_STOP  = 3'd1,
    PM_IDLE1 = 3'd2,
    PM_IDLE2 = 3'd3,
    PM_WARM  = 3'd4
  } pmode_t;

  localparam logic [1:0] ADDR_OSC  = 2'd0;
  localparam logic [1:0] ADDR_GEAR = 2'd1;
  localparam logic [1:0] ADDR_AUX  = 2'd2;

  localparam logic [2:0] GEAR_MAX = 3'd4;

  localparam logic [1:0] HM_STOP  = 2'b01;
  localparam logic [1:0] HM_IDLE1 = 2'b10;
  localparam logic [1:0] HM_IDLE2 = 2'b11;

endpackage

// File: rtl/clkgear_regs.sv
module clkgear_regs
  import clkgear_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       wake_load,
  input  logic       clk_switch,
  output logic       hosc_q,
  output logic       losc_q,
  output logic       hosc_ps_q,
  output logic       losc_ps_q,
  output logic       clk_ps_q,
  output logic [1:0] presc_q,
  output logic       sysck_q,
  output logic [2:0] gear_q,
  output logic       clkout_q,
  output logic [1:0] wulen_q,
  output logic [1:0] haltm_q,
  output logic       drv_tgt_q,
  output logic       pin_hold_q,
  output logic       sw_start
);

  logic       wr_osc, wr_gear, wr_aux;
  logic       hosc_d, losc_d, hosc_ps_d, losc_ps_d, clk_ps_d;
  logic [1:0] presc_d;
  logic       sysck_d;
  logic [2:0] gear_d;
  logic       clkout_d, drv_tgt_d, pin_hold_d;
  logic [1:0] wulen_d, haltm_d;

  assign wr_osc   = we && (addr == ADDR_OSC);
  assign wr_gear  = we && (addr == ADDR_GEAR);
  assign wr_aux   = we && (addr == ADDR_AUX);
  assign sw_start = wr_osc && wdata[2];

  always_comb begin
    hosc_d     = hosc_q;
    losc_d     = losc_q;
    hosc_ps_d  = hosc_ps_q;
    losc_ps_d  = losc_ps_q;
    clk_ps_d   = clk_ps_q;
    presc_d    = presc_q;
    sysck_d    = sysck_q;
    gear_d     = gear_q;
    clkout_d   = clkout_q;
    wulen_d    = wulen_q;
    haltm_d    = haltm_q;
    drv_tgt_d  = drv_tgt_q;
    pin_hold_d = pin_hold_q;
    if (wr_osc) begin
      hosc_d    = wdata[7];
      losc_d    = wdata[6];
      hosc_ps_d = wdata[5];
      losc_ps_d = wdata[4];
      clk_ps_d  = wdata[3];
      presc_d   = wdata[1:0];
    end
    if (wr_gear) begin
      sysck_d = wdata[3];
      if (wdata[2:0] <= GEAR_MAX) gear_d = wdata[2:0];
    end
    if (wr_aux) begin
      clkout_d   = wdata[6];
      wulen_d    = wdata[5:4];
      haltm_d    = wdata[3:2];
      drv_tgt_d  = wdata[1];
      pin_hold_d = wdata[0];
    end
    // hardware events take precedence over a same-cycle software write
    if (wake_load) begin
      hosc_d = hosc_ps_q;
      losc_d = losc_ps_q;
    end
    if (clk_switch) sysck_d = clk_ps_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hosc_q     <= 1'b1;
      losc_q     <= 1'b1;
      hosc_ps_q  <= 1'b1;
      losc_ps_q  <= 1'b0;
      clk_ps_q   <= 1'b0;
      presc_q    <= 2'b00;
      sysck_q    <= 1'b0;
      gear_q     <= 3'b100;
      clkout_q   <= 1'b0;
      wulen_q    <= 2'b10;
      haltm_q    <= 2'b11;
      drv_tgt_q  <= 1'b0;
      pin_hold_q <= 1'b0;
    end else begin
      hosc_q     <= hosc_d;
      losc_q     <= losc_d;
      hosc_ps_q  <= hosc_ps_d;
      losc_ps_q  <= losc_ps_d;
      clk_ps_q   <= clk_ps_d;
      presc_q    <= presc_d;
      sysck_q    <= sysck_d;
      gear_q     <= gear_d;
      clkout_q   <= clkout_d;
      wulen_q    <= wulen_d;
      haltm_q    <= haltm_d;
      drv_tgt_q  <= drv_tgt_d;
      pin_hold_q <= pin_hold_d;
    end
  end

endmodule

// File: rtl/clkgear_warmup.sv
module clkgear_warmup #(
  parameter int SHORT_EXP = 8,
  parameter int MID_EXP   = 14,
  parameter int LONG_EXP  = 16
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       start,
  input  logic [1:0] len_code,
  output logic       busy
);

  localparam int CNT_W = LONG_EXP;
  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'((64'd1 << SHORT_EXP) - 64'd1);
  localparam logic [CNT_W-1:0] LOAD_MID   = CNT_W'((64'd1 << MID_EXP) - 64'd1);
  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'((64'd1 << LONG_EXP) - 64'd1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             busy_d;

  always_comb begin
    unique case (len_code)
      2'b01:   load_val = LOAD_SHORT;
      2'b11:   load_val = LOAD_LONG;
      default: load_val = LOAD_MID;   // 10 and reserved 00
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start) begin
      cnt_d  = load_val;
      busy_d = 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

endmodule

// File: rtl/clkgear_halt.sv
module clkgear_halt
  import clkgear_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       halt_req,
  input  logic       wake,
  input  logic [1:0] haltm,
  input  logic       wu_busy,
  output pmode_t     state,
  output logic       wake_load,
  output logic       clk_switch
);

  pmode_t state_d;

  assign wake_load  = (state == PM_STOP) && wake;
  assign clk_switch = (state == PM_WARM) && !wu_busy;

  always_comb begin
    state_d = state;
    unique case (state)
      PM_RUN: begin
        if (halt_req) begin
          unique case (haltm)
            HM_STOP:  state_d = PM_STOP;
            HM_IDLE1: state_d = PM_IDLE1;
            HM_IDLE2: state_d = PM_IDLE2;
            default:  state_d = PM_RUN;
          endcase
        end
      end
      PM_STOP:  if (wake) state_d = PM_WARM;
      PM_IDLE1,
      PM_IDLE2: if (wake) state_d = PM_RUN;
      PM_WARM:  if (!wu_busy) state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state <= PM_RUN;
    else         state <= state_d;
  end

endmodule

// File: rtl/clkgear_ctrl.sv
module clkgear_ctrl
  import clkgear_pkg::*;
#(
  parameter int SHORT_EXP = 8,
  parameter int MID_EXP   = 14,
  parameter int LONG_EXP  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       halt_req,
  input  logic       wake,
  output logic       hosc_en,
  output logic       losc_en,
  output logic       sysclk_sel,
  output logic [2:0] gear_sel,
  output logic [1:0] presc_sel,
  output logic       clkout_sel,
  output logic [1:0] halt_mode,
  output logic       pin_off
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic       hosc_q, losc_q, hosc_ps_q, losc_ps_q, clk_ps_q;
  logic [1:0] presc_q, wulen_q, haltm_q;
  logic       sysck_q, clkout_q, drv_tgt_q, pin_hold_q, sw_start;
  logic [2:0] gear_q;
  logic       wu_busy, wake_load, clk_switch;
  pmode_t     state;

  clkgear_regs u_regs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .wake_load  (wake_load),
    .clk_switch (clk_switch),
    .hosc_q     (hosc_q),
    .losc_q     (losc_q),
    .hosc_ps_q  (hosc_ps_q),
    .losc_ps_q  (losc_ps_q),
    .clk_ps_q   (clk_ps_q),
    .presc_q    (presc_q),
    .sysck_q    (sysck_q),
    .gear_q     (gear_q),
    .clkout_q   (clkout_q),
    .wulen_q    (wulen_q),
    .haltm_q    (haltm_q),
    .drv_tgt_q  (drv_tgt_q),
    .pin_hold_q (pin_hold_q),
    .sw_start   (sw_start)
  );

  clkgear_warmup #(
    .SHORT_EXP (SHORT_EXP),
    .MID_EXP   (MID_EXP),
    .LONG_EXP  (LONG_EXP)
  ) u_warmup (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .start    (sw_start || wake_load),
    .len_code (wulen_q),
    .busy     (wu_busy)
  );

  clkgear_halt u_halt (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .halt_req   (halt_req),
    .wake       (wake),
    .haltm      (haltm_q),
    .wu_busy    (wu_busy),
    .state      (state),
    .wake_load  (wake_load),
    .clk_switch (clk_switch)
  );

  logic in_stop_side, in_idle1;
  assign in_stop_side = (state == PM_STOP) || (state == PM_WARM);
  assign in_idle1     = (state == PM_IDLE1);

  assign hosc_en    = hosc_q && (state != PM_STOP);
  assign losc_en    = losc_q && (state != PM_STOP);
  assign sysclk_sel = sysck_q;
  assign gear_sel   = gear_q;
  assign presc_sel  = presc_q;
  assign clkout_sel = clkout_q;
  assign pin_off    = !pin_hold_q &&
                      ((in_stop_side && !drv_tgt_q) || (in_idle1 && drv_tgt_q));

  always_comb begin
    unique case (state)
      PM_STOP, PM_WARM: halt_mode = HM_STOP;
      PM_IDLE1:         halt_mode = HM_IDLE1;
      PM_IDLE2:         halt_mode = HM_IDLE2;
      default:          halt_mode = 2'b00;
    endcase
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_OSC:  reg_rdata = {hosc_q, losc_q, hosc_ps_q, losc_ps_q, clk_ps_q,
                              wu_busy, presc_q};
      ADDR_GEAR: reg_rdata = {4'b0000, sysck_q, gear_q};
      ADDR_AUX:  reg_rdata = {1'b0, clkout_q, wulen_q, haltm_q, drv_tgt_q, pin_hold_q};
      default:   reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/clkgear_ctrl_chk.sv
module clkgear_ctrl_chk
  import clkgear_pkg::*;
(
  input logic       clk,
  input logic       rst_ni,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [2:0] wdata_lo,
  input logic       halt_req,
  input logic [1:0] haltm_q,
  input logic [2:0] gear_sel,
  input logic       sysclk_sel,
  input logic       hosc_en,
  input logic       losc_en,
  input logic [1:0] halt_mode,
  input pmode_t     state,
  input logic       wu_busy
);

  assert_gear_legal_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    gear_sel <= GEAR_MAX);

  assert_gear_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_we && reg_addr == ADDR_GEAR && wdata_lo > GEAR_MAX) |=> $stable(gear_sel));

  assert_wu_start_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_we && reg_addr == ADDR_OSC && wdata_lo[2]) |=> wu_busy);

  assert_stop_osc_off_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == PM_STOP) |-> (!hosc_en && !losc_en));

  assert_halt_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == PM_RUN && halt_req && haltm_q == 2'b00) |=> (halt_mode == 2'b00));

  assert_clk_switch_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!reg_we && state != PM_WARM) |=> $stable(sysclk_sel));

endmodule

bind clkgear_ctrl clkgear_ctrl_chk u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wdata_lo   (reg_wdata[2:0]),
  .halt_req   (halt_req),
  .haltm_q    (haltm_q),
  .gear_sel   (gear_sel),
  .sysclk_sel (sysclk_sel),
  .hosc_en    (hosc_en),
  .losc_en    (losc_en),
  .halt_mode  (halt_mode),
  .state      (state),
  .wu_busy    (wu_busy)
);

// File: tb/clkgear_ctrl_tb.sv
`timescale 1ns/1ps
module clkgear_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       halt_req = 1'b0;
  logic       wake = 1'b0;
  logic [7:0] reg_rdata;
  logic       hosc_en, losc_en, sysclk_sel, clkout_sel, pin_off;
  logic [2:0] gear_sel;
  logic [1:0] presc_sel, halt_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  clkgear_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt_req(halt_req),
    .wake(wake), .hosc_en(hosc_en), .losc_en(losc_en), .sysclk_sel(sysclk_sel),
    .gear_sel(gear_sel), .presc_sel(presc_sel), .clkout_sel(clkout_sel),
    .halt_mode(halt_mode), .pin_off(pin_off)
  );

  // ---------------- behavioural reference model ----------------
  // mode: 0 run, 1 stop, 2 idle1, 3 idle2, 4 warm-up after stop
  bit [7:0] m_osc;     // bit 2 unused, busy kept separately
  bit       m_sys;
  int       m_gear;
  bit [6:0] m_aux;
  int       m_mode;
  bit       m_busy;
  int       m_left;

  function automatic int wu_len(bit [1:0] c);
    if (c == 2'b01) return 256;
    if (c == 2'b11) return 65536;
    return 16384;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_osc = 8'hE0; m_sys = 0; m_gear = 4; m_aux = 7'h2C;
      m_mode = 0; m_busy = 0; m_left = 0;
    end else begin
      bit [7:0] n_osc; bit n_sys; int n_gear; bit [6:0] n_aux; int n_mode;
      bit start;
      n_osc = m_osc; n_sys = m_sys; n_gear = m_gear; n_aux = m_aux; n_mode = m_mode;
      start = 0;
      if (reg_we && reg_addr == 0) begin
        n_osc = reg_wdata & 8'hFB;
        if (reg_wdata[2]) start = 1;
      end
      if (reg_we && reg_addr == 1) begin
        n_sys = reg_wdata[3];
        if (reg_wdata[2:0] <= 4) n_gear = reg_wdata[2:0];
      end
      if (reg_we && reg_addr == 2) n_aux = reg_wdata[6:0];
      case (m_mode)
        0: if (halt_req && m_aux[3:2] != 0) n_mode = m_aux[3:2];
        1: if (wake) begin
             n_osc[7] = m_osc[5]; n_osc[6] = m_osc[4]; start = 1; n_mode = 4;
           end
        2, 3: if (wake) n_mode = 0;
        4: if (!m_busy) begin n_sys = m_osc[3]; n_mode = 0; end
        default: n_mode = 0;
      endcase
      if (start) begin
        m_busy = 1; m_left = wu_len(m_aux[5:4]) - 1;
      end else if (m_busy) begin
        if (m_left == 0) m_busy = 0; else m_left--;
      end
      m_osc = n_osc; m_sys = n_sys; m_gear = n_gear; m_aux = n_aux; m_mode = n_mode;
    end
  end

  function automatic bit [7:0] exp_rdata(bit [1:0] a);
    case (a)
      2'd0: return {m_osc[7:3], m_busy, m_osc[1:0]};
      2'd1: return {4'b0, m_sys, 3'(m_gear)};
      2'd2: return {1'b0, m_aux};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit hold, tgt; bit exp_off; int hm;
      hold = m_aux[0]; tgt = m_aux[1];
      exp_off = !hold && (((m_mode == 1 || m_mode == 4) && !tgt) || (m_mode == 2 && tgt));
      hm = (m_mode == 4) ? 1 : m_mode;
      chk(hosc_en == (m_osc[7] && m_mode != 1), "R9", "hosc_en", hosc_en, m_osc[7] && m_mode != 1);
      chk(losc_en == (m_osc[6] && m_mode != 1), "R9", "losc_en", losc_en, m_osc[6] && m_mode != 1);
      chk(sysclk_sel == m_sys, "R6", "sysclk_sel", sysclk_sel, m_sys);
      chk(gear_sel == m_gear, "R5", "gear_sel", gear_sel, m_gear);
      chk(presc_sel == m_osc[1:0], "R2", "presc_sel", presc_sel, m_osc[1:0]);
      chk(clkout_sel == m_aux[6], "R7", "clkout_sel", clkout_sel, m_aux[6]);
      chk(halt_mode == hm, "R8", "halt_mode", halt_mode, hm);
      chk(pin_off == exp_off, "R11", "pin_off", pin_off, exp_off);
      chk(reg_rdata == exp_rdata(reg_addr), (reg_addr == 0) ? "R3" :
          (reg_addr == 1) ? "R6" : "R7", "reg_rdata", reg_rdata, exp_rdata(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(posedge clk); #2; endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(bit [1:0] a, output bit [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic measure_busy(bit [1:0] code, int exp_len, bit mid_zero);
    int cnt; bit [7:0] d;
    wr(2, {2'b00, code, 4'b1100});       // halt 11, length code
    wr(0, 8'hE4);                        // start warm-up
    reg_addr = 0; #1;
    cnt = 0;
    while (reg_rdata[2]) begin
      cnt++;
      if (mid_zero && cnt == 10) begin
        reg_we = 1; reg_wdata = 8'hE0; tick(); reg_we = 0; #1;
      end else begin
        #1; tick(); #0;
      end
      #0;
    end
    chk(cnt == exp_len, "R4", "warm-up length", cnt, exp_len);
    rd(2, d);
    chk(d[5:4] == code, "R4", "length code readback", d[5:4], code);
  endtask

  initial begin
    bit [7:0] d;
    int cnt;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) tick();

    // R1 reset values
    rd(0, d); chk(d == 8'hE0, "R1", "reg0 reset", d, 8'hE0);
    rd(1, d); chk(d == 8'h04, "R1", "reg1 reset", d, 8'h04);
    rd(2, d); chk(d == 8'h2C, "R1", "reg2 reset", d, 8'h2C);
    chk(hosc_en && losc_en && halt_mode == 0, "R1", "reset outputs",
        {hosc_en, losc_en, halt_mode}, 4'b1100);

    // R2 register 0 fields
    wr(0, 8'h42); #1;
    chk(!hosc_en && losc_en && presc_sel == 2'b10, "R2", "osc/presc",
        {hosc_en, losc_en, presc_sel}, 4'b0110);
    wr(0, 8'hB9); #1;
    chk(hosc_en && !losc_en && presc_sel == 2'b01, "R2", "osc/presc reserved stored",
        {hosc_en, losc_en, presc_sel}, 4'b1001);

    // R5 gear codes and reserved hold
    for (int g = 0; g < 8; g++) begin
      wr(1, 8'(g)); #1;
      chk(gear_sel == ((g <= 4) ? g : 4), "R5", "gear code", gear_sel, (g <= 4) ? g : 4);
    end
    wr(1, 8'h02); wr(1, 8'h06); #1;
    chk(gear_sel == 2, "R5", "reserved gear keeps previous", gear_sel, 2);

    // R6 system clock select, upper bits read zero
    wr(1, 8'hF9); rd(1, d);
    chk(d == 8'h09 && sysclk_sel, "R6", "reg1 readback", d, 8'h09);
    wr(1, 8'h01); #1;
    chk(!sysclk_sel, "R6", "sysclk back to fast", sysclk_sel, 0);

    // R7 register 2 and the empty address
    wr(2, 8'hFF); rd(2, d);
    chk(d == 8'h7F && clkout_sel, "R7", "reg2 bit7 zero", d, 8'h7F);
    wr(3, 8'hFF); rd(3, d);
    chk(d == 8'h00, "R7", "addr3 reads zero", d, 0);
    rd(0, d); chk(d == 8'hB9 - 8'h00 && 1, "R7", "addr3 write left reg0", d, 8'hB9);
    rd(1, d); chk(d == 8'h01, "R7", "addr3 write left reg1", d, 8'h01);
    wr(2, 8'h2C);

    // R3 / R4 warm-up lengths
    measure_busy(2'b01, 256, 0);
    measure_busy(2'b01, 256, 1);       // R3 writing 0 mid-count has no effect
    measure_busy(2'b10, 16384, 0);
    measure_busy(2'b00, 16384, 0);
    measure_busy(2'b11, 65536, 0);

    // R8 reserved halt code ignored
    wr(2, 8'h10);
    halt_req = 1; tick(); halt_req = 0; #1;
    chk(halt_mode == 0, "R8", "reserved halt code", halt_mode, 0);

    // R8/R9/R11 IDLE1 with pins off, then wake
    wr(2, 8'h1A);                       // idle1, target idle1, no hold
    halt_req = 1; tick(); halt_req = 0; #1;
    chk(halt_mode == 2 && pin_off, "R11", "idle1 pins off", {halt_mode, pin_off}, 3'b101);
    wake = 1; tick(); wake = 0; #1;
    chk(halt_mode == 0, "R9", "idle1 wake", halt_mode, 0);

    // IDLE2: pin control not applied
    wr(2, 8'h1E);
    halt_req = 1; tick(); halt_req = 0; #1;
    chk(halt_mode == 3 && !pin_off, "R8", "idle2 entry", {halt_mode, pin_off}, 3'b110);
    wake = 1; tick(); wake = 0; #1;
    chk(halt_mode == 0, "R9", "idle2 wake", halt_mode, 0);

    // R9/R10/R11 STOP: post-stop fast off, slow on, select slow clock
    wr(1, 8'h00);
    wr(0, 8'hD8);                        // live both on, post-stop 01, clk slow
    wr(2, 8'h14);                        // length 256, STOP, target stop, no hold
    halt_req = 1; tick(); halt_req = 0; #1;
    chk(!hosc_en && !losc_en && halt_mode == 1, "R9", "stop osc off",
        {hosc_en, losc_en, halt_mode}, 4'b0001);
    chk(pin_off, "R11", "stop pins off", pin_off, 1);
    repeat (5) tick();
    wake = 1; tick(); wake = 0; #1;
    chk(!hosc_en && losc_en, "R10", "post-stop enables", {hosc_en, losc_en}, 2'b01);
    cnt = 0;
    while (!sysclk_sel && cnt < 400) begin
      chk(halt_mode == 1, "R10", "halt held during warm-up", halt_mode, 1);
      cnt++; tick(); #1;
    end
    chk(cnt == 257, "R10", "wake to clock switch", cnt, 257);
    chk(halt_mode == 0, "R10", "run after warm-up", halt_mode, 0);

    // R11 hold bit keeps pins in STOP
    wr(2, 8'h15);
    halt_req = 1; tick(); halt_req = 0; #1;
    chk(!pin_off && halt_mode == 1, "R11", "stop with hold", {pin_off, halt_mode}, 3'b001);
    wake = 1; tick(); wake = 0;
    repeat (300) tick();

    done = 1;
    summary();
  end

endmodule